// File: doc/BRIEF.md
# Dual-Input Capture/Reload Timer

A 16-bit down-counter with three operating modes, set through one 8-bit control/status register. In the reload mode the counter runs on every clock. Each time it passes zero it reloads, taking its value from the A reload register and the B reload register in turn. In the event mode it counts rising edges seen on input A and wraps from zero to all ones. In the capture mode it runs freely. A rising edge on input A copies the count into the A register, and a rising edge on input B copies it into the B register.

Software reaches the control register and the byte lanes of the two 16-bit registers and the counter over a small byte-wide register bus. Hardware sets the pending flags. Software clears a flag by writing a zero to it. A single interrupt line combines the two enable/pending pairs. In capture mode, bit 4 of the control register becomes an extra underflow pending flag, which is gated by the A enable. The counter and both 16-bit registers have no reset value, so software must load them before use.

Top module: `cap_reload_timer`

## Requirements
- R1: After reset the control register reads 0x00 and `irq` is low.
- R2: Register bus addresses: 0 is the control register, 1 and 2 are the low and high bytes of register A, 3 and 4 are the low and high bytes of register B, and 5 and 6 are the low and high bytes of the counter. Reads are combinational, and a write takes effect at the clock edge.
- R3: Control bits [7:5] select the mode: 100 is reload, 000 is event, 110 is capture. Any other code freezes the counter and ignores edges on both inputs.
- R4: In reload mode with bit 4 set, the counter decrements on every clock. The step taken at zero loads register A on the first pass, then register B, then A again, and so on. With bit 4 clear the counter holds.
- R5: In reload mode the A pending flag (bit 3) is set by a reload from register A and only by that. A reload from register B leaves it unchanged.
- R6: In event mode with bit 4 set, each rising edge on `in_a` decrements the counter once. The step from 0x0000 to 0xFFFF sets the A pending flag. With bit 4 clear, edges are ignored.
- R7: In capture mode the counter decrements on every clock. A rising edge on `in_a` copies the count held before the capture clock into register A and sets the A pending flag. An edge on `in_b` does the same with register B and the B pending flag (bit 1).
- R8: In capture mode, bit 4 is set when the counter steps from 0x0000 to 0xFFFF. Writing 0 to it clears it, and writing 1 to it does not set it.
- R9: Writing 0 to a pending flag clears it and writing 1 leaves it as it was. If a hardware set and a clear arrive at the same edge, the set wins.
- R10: `irq` = (bit3 & bit2) | (bit1 & bit0) | (capture mode & bit4 & bit2). It follows the register contents without an added cycle.
- R11: In reload and event modes, a rising edge on `in_b` sets the B pending flag and leaves register B unchanged.
- R12: Each input passes through a two-flop synchronizer. The edge acts at the third clock edge after the input rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| in_a | input | 1 | External input A (event / capture) |
| in_b | input | 1 | External input B (capture) |
| irq | output | 1 | Combined interrupt request |

## Verification
The reload mode is run with different values in registers A and B and compared step by step against a sequence table. The alternation and the flag that only register A raises can both be seen there. In event mode the bench sends isolated pulses with the run bit both set and clear, which separates counting of A edges from free running and from ignoring the input. The capture mode is started from a known count, so the exact values captured show the synchronizer latency and which clock's count is kept. The underflow flag is driven through its wrap, its clear and its write-1 cases. Halt codes and B edges in the non-capture modes confirm that nothing is captured where nothing should be.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    TM_HALT,
    TM_RELOAD,
    TM_EVENT,
    TM_CAPTURE
  } tmr_mode_e;

  // Mode code held in control bits [7:5]
  function automatic tmr_mode_e decode_mode(input logic [2:0] code);
    case (code)
      3'b100:  return TM_RELOAD;
      3'b000:  return TM_EVENT;
      3'b110:  return TM_CAPTURE;
      default: return TM_HALT;
    endcase
  endfunction

  // Pending flag update: hardware set wins, software may only clear
  function automatic logic flag_next(input logic cur, input logic hw_set,
                                     input logic sw_wr, input logic sw_bit);
    if (hw_set) return 1'b1;
    if (sw_wr)  return cur & sw_bit;
    return cur;
  endfunction

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], din};
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

  // R12
  rise_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/tmr_ctrl_reg.sv
module tmr_ctrl_reg
  import tmr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  logic [7:0] wr_data,
  input  logic      set_a,
  input  logic      set_b,
  input  logic      set_uf,
  output logic [7:0] ctrl,
  output tmr_mode_e mode,
  output logic      run,
  output logic      irq
);
  logic [2:0] code_q;
  logic       c0_q, pa_q, ea_q, pb_q, eb_q;
  tmr_mode_e  wr_mode;

  assign wr_mode = decode_mode(wr_data[7:5]);
  assign mode    = decode_mode(code_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= '0;
      c0_q   <= 1'b0;
      pa_q   <= 1'b0;
      ea_q   <= 1'b0;
      pb_q   <= 1'b0;
      eb_q   <= 1'b0;
    end else begin
      pa_q <= flag_next(pa_q, set_a, wr_en, wr_data[3]);
      pb_q <= flag_next(pb_q, set_b, wr_en, wr_data[1]);
      if (wr_en) begin
        code_q <= wr_data[7:5];
        ea_q   <= wr_data[2];
        eb_q   <= wr_data[0];
        if (wr_mode == TM_CAPTURE) c0_q <= flag_next(c0_q, set_uf, 1'b1, wr_data[4]);
        else                       c0_q <= wr_data[4];
      end else begin
        c0_q <= c0_q | set_uf;
      end
    end
  end

  assign ctrl = {code_q, c0_q, pa_q, ea_q, pb_q, eb_q};
  assign run  = c0_q;
  assign irq  = (pa_q & ea_q) | (pb_q & eb_q) | ((mode == TM_CAPTURE) & c0_q & ea_q);

  // R9
  pend_a_no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pa_q && !set_a) |=> !pa_q);
  // R9
  pend_b_no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pb_q && !set_b) |=> !pb_q);
  // R10
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ea_q && !eb_q) |-> !irq);
  // R8
  uf_flag_only_hw_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TM_CAPTURE && !c0_q && !set_uf && !(wr_en && wr_mode != TM_CAPTURE)) |=> !c0_q);
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tmr_mode_e         mode,
  input  logic              run,
  input  logic              edge_a,
  input  logic              edge_b,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic [CNT_W-1:0]  ra,
  output logic [CNT_W-1:0]  rb,
  output logic [CNT_W-1:0]  cnt,
  output logic              set_a,
  output logic              set_b,
  output logic              set_uf
);
  localparam int LANES = CNT_W / 8;

  logic [CNT_W-1:0] cnt_q, ra_q, rb_q;
  logic             sel_q;
  logic [LANES-1:0] wr_ra, wr_rb, wr_cnt;
  logic             cnt_wr, tick, underflow, reload_hit, cap_a, cap_b;

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      wr_ra[i]  = wr_en && (wr_addr == ADDR_W'(1 + i));
      wr_rb[i]  = wr_en && (wr_addr == ADDR_W'(1 + LANES + i));
      wr_cnt[i] = wr_en && (wr_addr == ADDR_W'(1 + 2*LANES + i));
    end
  end

  assign cnt_wr     = |wr_cnt;
  assign tick       = ((mode == TM_RELOAD) && run) ||
                      ((mode == TM_EVENT) && run && edge_a) ||
                      (mode == TM_CAPTURE);
  assign underflow  = tick && (cnt_q == '0);
  assign reload_hit = underflow && (mode == TM_RELOAD);
  assign cap_a      = (mode == TM_CAPTURE) && edge_a;
  assign cap_b      = (mode == TM_CAPTURE) && edge_b;

  always_ff @(posedge clk) begin
    if (reload_hit)  cnt_q <= sel_q ? rb_q : ra_q;
    else if (tick)   cnt_q <= cnt_q - 1'b1;
    for (int i = 0; i < LANES; i++)
      if (wr_cnt[i]) cnt_q[i*8 +: 8] <= wr_data;

    if (cap_a) ra_q <= cnt_q;
    else for (int i = 0; i < LANES; i++)
      if (wr_ra[i]) ra_q[i*8 +: 8] <= wr_data;

    if (cap_b) rb_q <= cnt_q;
    else for (int i = 0; i < LANES; i++)
      if (wr_rb[i]) rb_q[i*8 +: 8] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 sel_q <= 1'b0;
    else if (mode != TM_RELOAD) sel_q <= 1'b0;
    else if (reload_hit)        sel_q <= ~sel_q;
  end

  assign set_a  = (reload_hit && !sel_q) || ((mode == TM_EVENT) && underflow) || cap_a;
  assign set_b  = edge_b && (mode != TM_HALT);
  assign set_uf = (mode == TM_CAPTURE) && underflow;
  assign ra  = ra_q;
  assign rb  = rb_q;
  assign cnt = cnt_q;

  // R3
  halt_holds_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TM_HALT && !cnt_wr) |=> $stable(cnt_q));
  // R4
  reload_from_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_hit && !sel_q && !cnt_wr) |=> cnt_q == $past(ra_q));
  // R4
  reload_from_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_hit && sel_q && !cnt_wr) |=> cnt_q == $past(rb_q));
  // R7
  capture_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_a |=> ra_q == $past(cnt_q));
  // R7
  capture_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_b |=> rb_q == $past(cnt_q));
endmodule

// File: rtl/cap_reload_timer.sv
module cap_reload_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       in_a,
  input  logic       in_b,
  output logic       irq
);
  localparam int LANES  = CNT_W / 8;
  localparam int ADDR_W = 3;

  logic [1:0]       edges;
  logic [1:0]       raw_in;
  logic [7:0]       ctrl;
  tmr_mode_e        mode;
  logic             run, set_a, set_b, set_uf, ctrl_wr;
  logic [CNT_W-1:0] ra, rb, cnt;

  assign raw_in  = {in_b, in_a};
  assign ctrl_wr = bus_wr && (bus_addr == '0);

  for (genvar g = 0; g < 2; g++) begin : g_sync
    tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(raw_in[g]), .rise(edges[g]));
  end

  tmr_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(ctrl_wr), .wr_data(bus_wdata),
    .set_a(set_a), .set_b(set_b), .set_uf(set_uf),
    .ctrl(ctrl), .mode(mode), .run(run), .irq(irq));

  tmr_core #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_core (
    .clk(clk), .rst_n(rst_n), .mode(mode), .run(run),
    .edge_a(edges[0]), .edge_b(edges[1]),
    .wr_en(bus_wr), .wr_addr(bus_addr), .wr_data(bus_wdata),
    .ra(ra), .rb(rb), .cnt(cnt),
    .set_a(set_a), .set_b(set_b), .set_uf(set_uf));

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == '0) bus_rdata = ctrl;
    for (int i = 0; i < LANES; i++) begin
      if (bus_addr == ADDR_W'(1 + i))           bus_rdata = ra[i*8 +: 8];
      if (bus_addr == ADDR_W'(1 + LANES + i))   bus_rdata = rb[i*8 +: 8];
      if (bus_addr == ADDR_W'(1 + 2*LANES + i)) bus_rdata = cnt[i*8 +: 8];
    end
  end
endmodule

// File: tb/cap_reload_timer_bench.sv
module cap_reload_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       in_a = 1'b0;
  logic       in_b = 1'b0;
  logic       irq;

  int n_run = 0;
  int n_fail = 0;
  logic [15:0] v16;
  logic [7:0]  v8;

  // Reload-mode walk: {pendA, count} after each clock, RA=5, RB=2, start count 1
  localparam logic [16:0] M1_SEQ [12] = '{
    {1'b0, 16'd0}, {1'b1, 16'd5}, {1'b1, 16'd4}, {1'b1, 16'd3},
    {1'b1, 16'd2}, {1'b1, 16'd1}, {1'b1, 16'd0}, {1'b1, 16'd2},
    {1'b1, 16'd1}, {1'b1, 16'd0}, {1'b1, 16'd5}, {1'b1, 16'd4}};

  always #(CLK_PERIOD/2) clk = ~clk;

  cap_reload_timer u_cap_reload_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .in_a(in_a), .in_b(in_b), .irq(irq));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic rd16(input logic [2:0] lo, output logic [15:0] d);
    logic [7:0] l, h;
    rd(lo, l);
    rd(lo + 3'd1, h);
    d = {h, l};
  endtask

  task automatic wr16(input logic [2:0] lo, input logic [15:0] d);
    wr(lo, d[7:0]);
    wr(lo + 3'd1, d[15:8]);
  endtask

  task automatic pulse_a();
    in_a = 1'b1; step(2); in_a = 1'b0; step(3);
  endtask

  task automatic pulse_b();
    in_b = 1'b1; step(2); in_b = 1'b0; step(3);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    rd(3'd0, v8);
    check("R1 ctrl after reset", v8, 8'h00);
    check("R1 irq after reset", irq, 1'b0);

    // R2 register access, R3 halt code freezes counter
    wr(3'd0, 8'hE0);
    wr16(3'd1, 16'h1234);
    wr16(3'd3, 16'hABCD);
    wr16(3'd5, 16'h0F0F);
    rd16(3'd1, v16); check("R2 reg A readback", v16, 16'h1234);
    rd16(3'd3, v16); check("R2 reg B readback", v16, 16'hABCD);
    step(5);
    rd16(3'd5, v16); check("R3 halt holds count", v16, 16'h0F0F);
    wr(3'd0, 8'h30);
    step(4);
    rd16(3'd5, v16); check("R3 code 001 holds count", v16, 16'h0F0F);

    // R4 R5 reload walk driven by table
    wr(3'd0, 8'hE0);
    wr16(3'd1, 16'd5);
    wr16(3'd3, 16'd2);
    wr16(3'd5, 16'd1);
    wr(3'd0, 8'h90);
    for (int i = 0; i < 12; i++) begin
      step(1);
      rd16(3'd5, v16); check("R4 reload sequence count", v16, M1_SEQ[i][15:0]);
      rd(3'd0, v8);    check("R5 reload sequence pendA", v8[3], M1_SEQ[i][16]);
    end

    // R5 reload from B leaves cleared flag alone
    wr(3'd0, 8'hE0);
    wr16(3'd5, 16'd1);
    wr(3'd0, 8'h90);
    step(2);
    wr(3'd0, 8'h90);
    rd(3'd0, v8); check("R9 pendA cleared by write 0", v8[3], 1'b0);
    step(5);
    rd16(3'd5, v16); check("R4 reload from B", v16, 16'd2);
    rd(3'd0, v8);    check("R5 B reload sets no flag", v8[3], 1'b0);
    step(3);
    rd(3'd0, v8);    check("R5 A reload sets flag", v8[3], 1'b1);
    wr(3'd0, 8'h80);
    step(4);
    rd16(3'd5, v16); check("R4 run clear holds count", v16, 16'd4);

    // R6 event counting
    wr(3'd0, 8'hE0);
    wr16(3'd5, 16'd1);
    wr(3'd0, 8'h14);
    step(3);
    rd16(3'd5, v16); check("R6 no edge no count", v16, 16'd1);
    pulse_a();
    rd16(3'd5, v16); check("R6 one edge one step", v16, 16'd0);
    rd(3'd0, v8);    check("R6 no flag before wrap", v8[3], 1'b0);
    pulse_a();
    rd16(3'd5, v16); check("R6 wrap to all ones", v16, 16'hFFFF);
    rd(3'd0, v8);    check("R6 wrap sets pendA", v8[3], 1'b1);
    check("R10 irq from pendA and enA", irq, 1'b1);
    wr(3'd0, 8'h04);
    pulse_a();
    rd16(3'd5, v16); check("R6 edge ignored when stopped", v16, 16'hFFFF);
    check("R10 irq low after clear", irq, 1'b0);
    wr(3'd0, 8'h0C);
    rd(3'd0, v8); check("R9 write 1 does not set pendA", v8[3], 1'b0);

    // R7 R12 capture exact values
    wr(3'd0, 8'hE0);
    wr16(3'd5, 16'h1000);
    wr(3'd0, 8'hC1);
    in_a = 1'b1;
    step(2);
    rd(3'd0, v8); check("R12 no capture before third edge", v8[3], 1'b0);
    step(1);
    rd16(3'd1, v16); check("R7 capture into A", v16, 16'h0FFE);
    rd(3'd0, v8);    check("R7 capture sets pendA", v8[3], 1'b1);
    check("R10 irq masked without enA", irq, 1'b0);
    in_b = 1'b1;
    step(3);
    rd16(3'd3, v16); check("R7 capture into B", v16, 16'h0FFB);
    rd(3'd0, v8);    check("R7 capture sets pendB", v8[1], 1'b1);
    check("R10 irq from pendB and enB", irq, 1'b1);
    in_a = 1'b0; in_b = 1'b0;

    // R8 underflow flag in capture mode
    wr(3'd0, 8'hE0);
    wr16(3'd5, 16'd2);
    wr(3'd0, 8'hC4);
    step(2);
    rd(3'd0, v8); check("R8 no flag before wrap", v8[4], 1'b0);
    step(1);
    rd(3'd0, v8); check("R8 wrap sets flag", v8[4], 1'b1);
    check("R10 irq from underflow flag", irq, 1'b1);
    wr(3'd0, 8'hD4);
    rd(3'd0, v8); check("R8 write 1 keeps flag", v8[4], 1'b1);
    wr(3'd0, 8'hC4);
    rd(3'd0, v8); check("R8 write 0 clears flag", v8[4], 1'b0);
    check("R10 irq low after flag clear", irq, 1'b0);
    wr(3'd0, 8'hD4);
    rd(3'd0, v8); check("R8 write 1 does not set flag", v8[4], 1'b0);

    // R11 B edge in reload mode, R3 B edge ignored when halted
    wr(3'd0, 8'hE0);
    wr16(3'd3, 16'h5A5A);
    wr(3'd0, 8'h80);
    pulse_b();
    rd(3'd0, v8);    check("R11 B edge sets pendB in reload mode", v8[1], 1'b1);
    rd16(3'd3, v16); check("R11 B register untouched", v16, 16'h5A5A);
    wr(3'd0, 8'hE0);
    pulse_b();
    rd(3'd0, v8); check("R3 B edge ignored when halted", v8[1], 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule